// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block produces the next program counter for a 32-bit RISC core once a control-transfer instruction has been decoded. Each cycle it takes the current PC, a 3-bit transfer kind, the two source register values, the 16-bit branch displacement, the 26-bit jump field, the 5-bit second-register field and the destination register index. One clock later it returns the next PC, a taken flag and a valid flag. For the two call forms it also returns the return address and the register that receives it.

Conditional branches either compare two registers for equality or inequality, or compare one register with zero. In the zero-compare case the second-register field of the instruction acts as an opcode extension that picks the condition. The branch displacement counts instructions, not bytes, and is measured from the instruction after the branch. No base register is involved, so the offset is added to the PC. Direct jumps build their target from the upper PC bits and the jump field. Register jumps take the target from the first register operand.

Top module: `npc_unit`

## Requirements
- R1: While reset is low and in the first cycle after it is released, every output is zero.
- R2: All results are registered. The outputs that follow a rising edge where `in_valid_i` was high describe the inputs sampled at that edge, and `out_valid_o` is 1. After an edge where `in_valid_i` was low, `out_valid_o`, `taken_o` and `link_we_o` are all 0.
- R3: Transfer kind 1 (equal branch) is taken exactly when `rs_val_i == rt_val_i`. Kind 2 (not-equal branch) is taken exactly when the two values differ.
- R4: Transfer kind 3 compares `rs_val_i`, read as a signed number, with zero. The condition comes from `rt_field_i`: 0 means less than zero, 1 means greater or equal, 2 means less or equal, 3 means greater than zero. Any other code is never taken.
- R5: The target of a taken branch is PC+4 plus the sign-extended displacement shifted left by two. For example, displacement 0xFFF9 at PC 0x00400044 gives 0x0040002C.
- R6: When no transfer is taken, including kind 0 (no transfer), `next_pc_o` is PC+4 and `link_we_o` is 0.
- R7: Kinds 4 (jump) and 5 (jump and link) are always taken. Their target is the upper 4 bits of PC+4, then the 26-bit jump field, then two zero bits.
- R8: Kinds 6 (register jump) and 7 (register jump and link) are always taken, with `next_pc_o` equal to `rs_val_i`.
- R9: Kind 5 sets `link_we_o` with `link_reg_o` = 31 and `link_val_o` = PC+4.
- R10: Kind 7 sets `link_we_o` with `link_reg_o` = `rd_idx_i` and `link_val_o` = PC+4. `link_val_o` and `link_reg_o` carry meaning only while `link_we_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid_i | input | 1 | A decoded instruction is presented |
| pc_i | input | 32 | Byte address of the instruction |
| xfer_i | input | 3 | Transfer kind, 0 to 7 as listed in the requirements |
| rs_val_i | input | 32 | First register operand |
| rt_val_i | input | 32 | Second register operand |
| rt_field_i | input | 5 | Second-register field, used as the zero-compare condition code |
| disp_i | input | 16 | Branch displacement in instructions |
| jfield_i | input | 26 | Direct jump field |
| rd_idx_i | input | 5 | Link destination for the register jump-and-link form |
| out_valid_o | output | 1 | Result registered this cycle |
| next_pc_o | output | 32 | Next program counter |
| taken_o | output | 1 | Control transfer taken |
| link_we_o | output | 1 | Write the return address |
| link_reg_o | output | 5 | Register that receives the return address |
| link_val_o | output | 32 | Return address (PC+4) |

## Verification
Every result is due exactly one rising edge after the cycle in which its inputs are presented. There is one register stage and no combinational path to the outputs. The driver applies each instruction on a falling edge and queues the expected result. The monitor waits for the next rising edge plus a short settle delay, then pops and compares, so each queued item meets its output in the cycle it is due. Idle cycles are queued as well, to confirm that the valid, taken and link-enable flags drop.

// File: rtl/npc_pkg.sv
package npc_pkg;

    typedef enum logic [2:0] {
        XFER_NONE     = 3'd0,
        XFER_BEQ      = 3'd1,
        XFER_BNE      = 3'd2,
        XFER_BZC      = 3'd3,
        XFER_JDIR     = 3'd4,
        XFER_JDIR_LNK = 3'd5,
        XFER_JREG     = 3'd6,
        XFER_JREG_LNK = 3'd7
    } xfer_e;

    localparam logic [4:0] ZC_LTZ = 5'd0;
    localparam logic [4:0] ZC_GEZ = 5'd1;
    localparam logic [4:0] ZC_LEZ = 5'd2;
    localparam logic [4:0] ZC_GTZ = 5'd3;

endpackage

// File: rtl/npc_cond_eval.sv
module npc_cond_eval
    import npc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  xfer_e            kind_i,
    input  logic [XLEN-1:0]  rs_i,
    input  logic [XLEN-1:0]  rt_i,
    input  logic [4:0]       zcode_i,
    output logic             cond_o
);
    logic is_neg;
    logic is_zero;
    logic zc_hit;

    assign is_neg  = rs_i[XLEN-1];
    assign is_zero = (rs_i == '0);

    always_comb begin
        unique case (zcode_i)
            ZC_LTZ:  zc_hit = is_neg;
            ZC_GEZ:  zc_hit = !is_neg;
            ZC_LEZ:  zc_hit = is_neg || is_zero;
            ZC_GTZ:  zc_hit = !is_neg && !is_zero;
            default: zc_hit = 1'b0;
        endcase
    end

    always_comb begin
        unique case (kind_i)
            XFER_BEQ:      cond_o = (rs_i == rt_i);
            XFER_BNE:      cond_o = (rs_i != rt_i);
            XFER_BZC:      cond_o = zc_hit;
            XFER_JDIR,
            XFER_JDIR_LNK,
            XFER_JREG,
            XFER_JREG_LNK: cond_o = 1'b1;
            default:       cond_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/npc_target_gen.sv
module npc_target_gen #(
    parameter int XLEN     = 32,
    parameter int DISP_W   = 16,
    parameter int JFIELD_W = 26
) (
    input  logic [XLEN-1:0]     pc_i,
    input  logic [DISP_W-1:0]   disp_i,
    input  logic [JFIELD_W-1:0] jfield_i,
    output logic [XLEN-1:0]     seq_o,
    output logic [XLEN-1:0]     br_tgt_o,
    output logic [XLEN-1:0]     j_tgt_o
);
    localparam int WORD_SHIFT = 2;
    localparam int INSTR_B    = 1 << WORD_SHIFT;
    localparam int SEXT_W     = XLEN - DISP_W - WORD_SHIFT;
    localparam int REGION_W   = XLEN - JFIELD_W - WORD_SHIFT;

    logic [XLEN-1:0] byte_off;

    assign seq_o    = pc_i + XLEN'(INSTR_B);
    assign byte_off = {{SEXT_W{disp_i[DISP_W-1]}}, disp_i, {WORD_SHIFT{1'b0}}};
    assign br_tgt_o = seq_o + byte_off;
    assign j_tgt_o  = {seq_o[XLEN-1 -: REGION_W], jfield_i, {WORD_SHIFT{1'b0}}};
endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int DISP_W    = 16,
    parameter int JFIELD_W  = 26,
    parameter int REG_W     = 5,
    parameter int RET_REG   = 31
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid_i,
    input  logic [XLEN-1:0]     pc_i,
    input  logic [2:0]          xfer_i,
    input  logic [XLEN-1:0]     rs_val_i,
    input  logic [XLEN-1:0]     rt_val_i,
    input  logic [REG_W-1:0]    rt_field_i,
    input  logic [DISP_W-1:0]   disp_i,
    input  logic [JFIELD_W-1:0] jfield_i,
    input  logic [REG_W-1:0]    rd_idx_i,
    output logic                out_valid_o,
    output logic [XLEN-1:0]     next_pc_o,
    output logic                taken_o,
    output logic                link_we_o,
    output logic [REG_W-1:0]    link_reg_o,
    output logic [XLEN-1:0]     link_val_o
);
    localparam logic [REG_W-1:0] RET_IDX = REG_W'(RET_REG);

    typedef struct packed {
        logic             vld;
        logic [XLEN-1:0]  npc;
        logic             tk;
        logic             lwe;
        logic [REG_W-1:0] lreg;
        logic [XLEN-1:0]  lval;
    } res_t;

    xfer_e           kind;
    logic            cond;
    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] br_tgt;
    logic [XLEN-1:0] j_tgt;
    res_t            res_d;
    res_t            res_q;

    assign kind = xfer_e'(xfer_i);

    npc_cond_eval #(.XLEN(XLEN)) i_cond (
        .kind_i  (kind),
        .rs_i    (rs_val_i),
        .rt_i    (rt_val_i),
        .zcode_i (rt_field_i),
        .cond_o  (cond)
    );

    npc_target_gen #(.XLEN(XLEN), .DISP_W(DISP_W), .JFIELD_W(JFIELD_W)) i_tgt (
        .pc_i     (pc_i),
        .disp_i   (disp_i),
        .jfield_i (jfield_i),
        .seq_o    (seq_pc),
        .br_tgt_o (br_tgt),
        .j_tgt_o  (j_tgt)
    );

    always_comb begin
        res_d      = '0;
        res_d.vld  = in_valid_i;
        res_d.npc  = seq_pc;
        res_d.lval = seq_pc;
        res_d.lreg = RET_IDX;
        if (in_valid_i) begin
            res_d.tk = cond;
            unique case (kind)
                XFER_BEQ, XFER_BNE, XFER_BZC: begin
                    if (cond) res_d.npc = br_tgt;
                end
                XFER_JDIR: res_d.npc = j_tgt;
                XFER_JDIR_LNK: begin
                    res_d.npc = j_tgt;
                    res_d.lwe = 1'b1;
                end
                XFER_JREG: res_d.npc = rs_val_i;
                XFER_JREG_LNK: begin
                    res_d.npc  = rs_val_i;
                    res_d.lwe  = 1'b1;
                    res_d.lreg = rd_idx_i;
                end
                default: res_d.npc = seq_pc;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_valid_o = res_q.vld;
    assign next_pc_o   = res_q.npc;
    assign taken_o     = res_q.tk;
    assign link_we_o   = res_q.lwe;
    assign link_reg_o  = res_q.lreg;
    assign link_val_o  = res_q.lval;

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid_i |=> (!out_valid_o && !taken_o && !link_we_o));

    // R6
    fallthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i |=> (taken_o || (next_pc_o == $past(pc_i) + XLEN'(4) && !link_we_o)));

    // R7
    jump_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && xfer_i[2]) |=> taken_o);

    // R8
    regjump_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && xfer_i[2:1] == 2'b11) |=> (next_pc_o == $past(rs_val_i)));

    // R9
    call_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && xfer_i == 3'd5) |=> (link_we_o && link_reg_o == RET_IDX));

    // R10
    link_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i |=> (!link_we_o || link_val_o == $past(pc_i) + XLEN'(4)));
endmodule

// File: tb/test_npc_unit.sv
module test_npc_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid_i = 1'b0;
    logic [31:0] pc_i = '0;
    logic [2:0]  xfer_i = '0;
    logic [31:0] rs_val_i = '0;
    logic [31:0] rt_val_i = '0;
    logic [4:0]  rt_field_i = '0;
    logic [15:0] disp_i = '0;
    logic [25:0] jfield_i = '0;
    logic [4:0]  rd_idx_i = '0;
    logic        out_valid_o;
    logic [31:0] next_pc_o;
    logic        taken_o;
    logic        link_we_o;
    logic [4:0]  link_reg_o;
    logic [31:0] link_val_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic        vld;
        logic [31:0] npc;
        logic        tk;
        logic        lwe;
        logic [4:0]  lreg;
        logic [31:0] lval;
        string       req;
    } exp_t;

    exp_t sb[$];

    always #2 clk = ~clk;

    npc_unit i_npc_unit (
        .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .pc_i(pc_i),
        .xfer_i(xfer_i), .rs_val_i(rs_val_i), .rt_val_i(rt_val_i),
        .rt_field_i(rt_field_i), .disp_i(disp_i), .jfield_i(jfield_i),
        .rd_idx_i(rd_idx_i), .out_valid_o(out_valid_o), .next_pc_o(next_pc_o),
        .taken_o(taken_o), .link_we_o(link_we_o), .link_reg_o(link_reg_o),
        .link_val_o(link_val_o)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Expected result from the requirements: R3..R10
    function automatic exp_t predict(input logic [2:0] k, input logic [31:0] pc,
            input logic [31:0] rs, input logic [31:0] rt, input logic [4:0] zc,
            input logic [15:0] d, input logic [25:0] jf, input logic [4:0] rd,
            input string req);
        exp_t e;
        logic [31:0] seq;
        logic        c;
        seq = pc + 32'd4;
        c = 1'b0;
        case (k)
            3'd1: c = (rs == rt);
            3'd2: c = (rs != rt);
            3'd3: case (zc)
                      5'd0: c = $signed(rs) < 0;
                      5'd1: c = $signed(rs) >= 0;
                      5'd2: c = $signed(rs) <= 0;
                      5'd3: c = $signed(rs) > 0;
                      default: c = 1'b0;
                  endcase
            3'd4, 3'd5, 3'd6, 3'd7: c = 1'b1;
            default: c = 1'b0;
        endcase
        e.vld = 1'b1; e.tk = c; e.lwe = (k == 3'd5 || k == 3'd7);
        e.lreg = (k == 3'd7) ? rd : 5'd31;
        e.lval = seq; e.req = req;
        if (!c) e.npc = seq;
        else if (k == 3'd4 || k == 3'd5) e.npc = {seq[31:28], jf, 2'b00};
        else if (k >= 3'd6) e.npc = rs;
        else e.npc = seq + {{14{d[15]}}, d, 2'b00};
        return e;
    endfunction

    task automatic issue(input logic [2:0] k, input logic [31:0] pc,
            input logic [31:0] rs, input logic [31:0] rt, input logic [4:0] zc,
            input logic [15:0] d, input logic [25:0] jf, input logic [4:0] rd,
            input string req);
        @(negedge clk);
        in_valid_i = 1'b1; xfer_i = k; pc_i = pc; rs_val_i = rs; rt_val_i = rt;
        rt_field_i = zc; disp_i = d; jfield_i = jf; rd_idx_i = rd;
        sb.push_back(predict(k, pc, rs, rt, zc, d, jf, rd, req));
    endtask

    task automatic idle(input string req);
        exp_t e;
        @(negedge clk);
        in_valid_i = 1'b0;
        xfer_i = 3'd5;
        e.vld = 1'b0; e.npc = '0; e.tk = 1'b0; e.lwe = 1'b0;
        e.lreg = '0; e.lval = '0; e.req = req;
        sb.push_back(e);
    endtask

    // Monitor: result is due one rising edge after the driving falling edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(e.req, "valid", {31'd0, out_valid_o}, {31'd0, e.vld});
                check(e.req, "taken", {31'd0, taken_o}, {31'd0, e.tk});
                check(e.req, "link_we", {31'd0, link_we_o}, {31'd0, e.lwe});
                if (e.vld) check(e.req, "next_pc", next_pc_o, e.npc);
                if (e.lwe) begin
                    check(e.req, "link_reg", {27'd0, link_reg_o}, {27'd0, e.lreg});
                    check(e.req, "link_val", link_val_o, e.lval);
                end
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check("R1", "valid", {31'd0, out_valid_o}, 32'd0);
        check("R1", "next_pc", next_pc_o, 32'd0);
        check("R1", "link_val", link_val_o, 32'd0);
        check("R1", "link_reg", {27'd0, link_reg_o}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1", "taken", {31'd0, taken_o}, 32'd0);

        // R3 equality / inequality branches
        issue(3'd1, 32'h0000_1000, 32'd7, 32'd7, 5'd0, 16'h0010, '0, '0, "R3");
        issue(3'd1, 32'h0000_1000, 32'd7, 32'd8, 5'd0, 16'h0010, '0, '0, "R3");
        issue(3'd2, 32'h0000_2000, 32'd7, 32'd8, 5'd0, 16'h0003, '0, '0, "R3");
        issue(3'd2, 32'h0000_2000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd0, 16'h0003, '0, '0, "R3");
        // R4 zero compares with negative, zero, positive operands
        for (int code = 0; code < 4; code++) begin
            issue(3'd3, 32'h0000_3000, 32'h8000_0000, '0, 5'(code), 16'h0002, '0, '0, "R4");
            issue(3'd3, 32'h0000_3000, 32'd0, '0, 5'(code), 16'h0002, '0, '0, "R4");
            issue(3'd3, 32'h0000_3000, 32'd5, '0, 5'(code), 16'h0002, '0, '0, "R4");
        end
        issue(3'd3, 32'h0000_3000, 32'hFFFF_FFF0, '0, 5'd7, 16'h0002, '0, '0, "R4");
        issue(3'd3, 32'h0000_3000, 32'd0, '0, 5'd17, 16'h0002, '0, '0, "R4");
        // R5 backward displacement, expected 0x0040002C
        issue(3'd2, 32'h0040_0044, 32'd1, 32'd0, 5'd0, 16'hFFF9, '0, '0, "R5");
        issue(3'd1, 32'h0000_0000, 32'd0, 32'd0, 5'd0, 16'h7FFF, '0, '0, "R5");
        // R6 no transfer
        issue(3'd0, 32'h1234_5678, 32'd1, 32'd2, 5'd0, 16'h0040, 26'h3FF_FFFF, 5'd9, "R6");
        idle("R2");
        // R7 direct jump, region bits from PC+4
        issue(3'd4, 32'hF000_0010, '0, '0, 5'd0, '0, 26'h012_3456, '0, "R7");
        issue(3'd4, 32'h1FFF_FFFC, '0, '0, 5'd0, '0, 26'h000_0001, '0, "R7");
        // R9 jump and link
        issue(3'd5, 32'h0040_0100, '0, '0, 5'd0, '0, 26'h010_0000, 5'd4, "R9");
        // R8 register jump
        issue(3'd6, 32'h0040_0200, 32'h0040_1234, '0, 5'd0, '0, '0, 5'd2, "R8");
        // R10 register jump and link
        issue(3'd7, 32'h0040_0300, 32'h0050_0000, '0, 5'd0, '0, '0, 5'd5, "R10");
        idle("R2");
        issue(3'd7, 32'hFFFF_FFFC, 32'h0000_0040, '0, 5'd0, '0, '0, 5'd31, "R10");
        idle("R2");
        idle("R2");

        while (sb.size() > 0) @(posedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule